// File: doc/BRIEF.md
# Four-Session Tile Self-Test Diagnoser

This block runs the built-in self-test of a tile of four logic cells, labelled A, B, C and D. The test has four sessions. In each one the block gives every cell one of four roles: pattern generator, response analyser, first unit under test or second unit under test. The roles rotate so that each cell is a generator once, an analyser once and a unit under test twice. During a session the block sweeps every input combination of the cells in counting order. Each cycle it compares the two unit-under-test responses and keeps a pass or fail result for the session.

After the fourth session the four results are decoded at once, with no second, adaptive phase. The decode gives one of three answers: the tile is clean, exactly one named cell is faulty, or the fault lies outside the cells. The cells themselves are outside this block. Their role codes and the shared input vector leave on output ports. Their two responses come back on two input pins.

The state machine has four states:
- IDLE waits for a start pulse.
- SWEEP steps the vector counter, one comparison per cycle.
- CLOSE stores the session result and moves to the next session, or to DECODE after the fourth.
- DECODE registers the location and raises done.

The transitions are:
- IDLE→SWEEP on start.
- SWEEP→SWEEP until the last vector, then SWEEP→CLOSE.
- CLOSE→SWEEP for sessions 1 to 3, and CLOSE→DECODE after session 4.
- DECODE→IDLE.

Top module: `tile_diag_top`

## Requirements
- R1: role_o[2*i+1:2*i] is the role of cell i, where A=0, B=1, C=2 and D=3. The codes are 00 = generator, 01 = analyser, 10 = first unit under test and 11 = second unit under test. In session s (0..3) cell i holds code (s - i) mod 4. Exactly one cell has code 00 at any time.
- R2: In each session vec_o takes the values 0 to 2^IN_W-1 in increasing order, one value per cycle. Session s vector j is presented in the cycle 9s+j after the edge that samples start (for IN_W=3).
- R3: ora_bit_o is a registered value. In the cycle after a sweep cycle it equals resp0_i XOR resp1_i from that sweep cycle.
- R4: A session fails if any of its comparisons mismatched, and passes otherwise. Results do not carry over from one session into the next.
- R5: In the result signature, bit s is 1 when session s+1 failed. The signatures map to a faulty cell as follows, with loc_o one-hot and bit0 = A:
  - 1100 and 1110 give A.
  - 1001 and 1101 give B.
  - 0011 and 1011 give C.
  - 0110 and 0111 give D.
- R6: A signature of 0000 raises nofault_o, with loc_o = 0 and outside_o = 0.
- R7: Every other signature raises outside_o, with loc_o = 0 and nofault_o = 0. These are any single fail, 0101, 1010 and 1111.
- R8: done_o is a one-cycle pulse that rises 4*(2^IN_W+1)+1 cycles after the edge that samples start. loc_o, nofault_o and outside_o are valid with it and are held until the next accepted start, which clears them.
- R9: A start pulse during a run is ignored. The run finishes with its own result at its normal time.
- R10: A synchronous active-high reset returns the block to IDLE. It clears the session counter, the vector counter, the stored results, done_o and the location outputs, so vec_o = 0 and role_o shows the session-0 map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a four-session test |
| resp0_i | input | 1 | Response of the first unit under test |
| resp1_i | input | 1 | Response of the second unit under test |
| role_o | output | 8 | Two-bit role code per cell, cell A in the low bits |
| vec_o | output | IN_W | Exhaustive test vector applied to the cells |
| ora_bit_o | output | 1 | Registered per-cycle mismatch bit |
| done_o | output | 1 | One-cycle pulse when the diagnosis is valid |
| loc_o | output | 4 | One-hot faulty cell, bit0 = A |
| nofault_o | output | 1 | Tile found clean |
| outside_o | output | 1 | Fault lies outside the cells |

## Verification
The bench builds the block with IN_W = 3. That gives 8 vectors per session and a run of 37 cycles, so a full diagnosis takes only a few dozen cycles.

At that size the bench can do three sweeps. It forces all 16 pass/fail signatures by injecting a mismatch in chosen sessions. It injects a single-vector fault into every cell at every one of the 8 vector positions through a behavioural cell model. It also traces the role map, the vector order and the mismatch bit cycle by cycle against the session arithmetic.

// File: rtl/tile_diag_pkg.sv
package tile_diag_pkg;

    localparam int unsigned NCELL = 4;
    localparam int unsigned SESS_W = $clog2(NCELL);

    typedef enum logic [1:0] {
        ROLE_GEN = 2'd0,
        ROLE_ANA = 2'd1,
        ROLE_UT0 = 2'd2,
        ROLE_UT1 = 2'd3
    } role_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SWEEP  = 2'd1,
        ST_CLOSE  = 2'd2,
        ST_DECODE = 2'd3
    } state_e;

endpackage

// File: rtl/tile_diag_roles.sv
module tile_diag_roles
    import tile_diag_pkg::*;
(
    input  logic [SESS_W-1:0]  sess_i,
    output logic [2*NCELL-1:0] role_o
);

    // Role index rotates by one cell per session: (session - cell) mod 4.
    for (genvar gi = 0; gi < NCELL; gi++) begin : g_cell
        assign role_o[2*gi +: 2] = SESS_W'(sess_i - SESS_W'(gi));
    end

endmodule

// File: rtl/tile_diag_ora.sv
module tile_diag_ora (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic clear_i,
    input  logic resp0_i,
    input  logic resp1_i,
    output logic ora_bit_o,
    output logic sess_fail_o
);

    logic mismatch;
    assign mismatch = resp0_i ^ resp1_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ora_bit_o   <= 1'b0;
            sess_fail_o <= 1'b0;
        end else begin
            if (en_i) begin
                ora_bit_o <= mismatch;
            end
            if (clear_i) begin
                sess_fail_o <= 1'b0;
            end else if (en_i) begin
                sess_fail_o <= sess_fail_o | mismatch;
            end
        end
    end

endmodule

// File: rtl/tile_diag_decode.sv
module tile_diag_decode
    import tile_diag_pkg::*;
(
    input  logic [NCELL-1:0] res_i,
    output logic [NCELL-1:0] loc_o,
    output logic             nofault_o,
    output logic             outside_o
);

    // A faulty cell fails the two sessions where it is under test, and
    // possibly also the session where it analyses.
    always_comb begin
        logic [NCELL-1:0] pair;
        logic [NCELL-1:0] ana;
        loc_o = '0;
        for (int i = 0; i < NCELL; i++) begin
            pair = '0;
            ana  = '0;
            pair[(i + 2) % NCELL] = 1'b1;
            pair[(i + 3) % NCELL] = 1'b1;
            ana[(i + 1) % NCELL]  = 1'b1;
            if (res_i == pair || res_i == (pair | ana)) begin
                loc_o[i] = 1'b1;
            end
        end
        nofault_o = (res_i == '0);
        outside_o = !nofault_o && (loc_o == '0);
    end

endmodule

// File: rtl/tile_diag_top.sv
module tile_diag_top
    import tile_diag_pkg::*;
#(
    parameter int unsigned IN_W = 3
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               start_i,
    input  logic               resp0_i,
    input  logic               resp1_i,
    output logic [2*NCELL-1:0] role_o,
    output logic [IN_W-1:0]    vec_o,
    output logic               ora_bit_o,
    output logic               done_o,
    output logic [NCELL-1:0]   loc_o,
    output logic               nofault_o,
    output logic               outside_o
);

    localparam logic [IN_W-1:0]   VEC_LAST  = {IN_W{1'b1}};
    localparam logic [SESS_W-1:0] SESS_LAST = SESS_W'(NCELL - 1);

    state_e            state_q, state_d;
    logic [SESS_W-1:0] sess_q;
    logic [IN_W-1:0]   vec_q;
    logic [NCELL-1:0]  res_q;
    logic [NCELL-1:0]  loc_q;
    logic              nof_q, out_q, done_q;
    logic              sess_fail;
    logic [NCELL-1:0]  dec_loc;
    logic              dec_nof, dec_out;

    tile_diag_roles u_roles (
        .sess_i (sess_q),
        .role_o (role_o)
    );

    tile_diag_ora u_ora (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .en_i        (state_q == ST_SWEEP),
        .clear_i     (state_q == ST_CLOSE),
        .resp0_i     (resp0_i),
        .resp1_i     (resp1_i),
        .ora_bit_o   (ora_bit_o),
        .sess_fail_o (sess_fail)
    );

    tile_diag_decode u_dec (
        .res_i     (res_q),
        .loc_o     (dec_loc),
        .nofault_o (dec_nof),
        .outside_o (dec_out)
    );

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_SWEEP;
            ST_SWEEP:  if (vec_q == VEC_LAST) state_d = ST_CLOSE;
            ST_CLOSE:  state_d = (sess_q == SESS_LAST) ? ST_DECODE : ST_SWEEP;
            ST_DECODE: state_d = ST_IDLE;
        endcase
    end

    // Counters, results and registered outputs
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sess_q <= '0;
            vec_q  <= '0;
            res_q  <= '0;
            loc_q  <= '0;
            nof_q  <= 1'b0;
            out_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        sess_q <= '0;
                        vec_q  <= '0;
                        res_q  <= '0;
                        loc_q  <= '0;
                        nof_q  <= 1'b0;
                        out_q  <= 1'b0;
                    end
                end
                ST_SWEEP: begin
                    vec_q <= vec_q + 1'b1;
                end
                ST_CLOSE: begin
                    res_q[sess_q] <= sess_fail;
                    sess_q        <= sess_q + 1'b1;
                end
                ST_DECODE: begin
                    loc_q  <= dec_loc;
                    nof_q  <= dec_nof;
                    out_q  <= dec_out;
                    done_q <= 1'b1;
                end
            endcase
        end
    end

    assign vec_o     = vec_q;
    assign done_o    = done_q;
    assign loc_o     = loc_q;
    assign nofault_o = nof_q;
    assign outside_o = out_q;

endmodule

// File: rtl/tile_diag_chk.sv
module tile_diag_chk
    import tile_diag_pkg::*;
#(
    parameter int unsigned IN_W = 3
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               start_i,
    input logic               resp0_i,
    input logic               resp1_i,
    input logic [2*NCELL-1:0] role_o,
    input logic [IN_W-1:0]    vec_o,
    input logic               ora_bit_o,
    input logic               done_o,
    input logic [NCELL-1:0]   loc_o,
    input logic               nofault_o,
    input logic               outside_o,
    input state_e             state_q
);

    localparam logic [IN_W-1:0] VEC_LAST = {IN_W{1'b1}};

    assert_one_gen_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        ((role_o[1:0] == 2'd0) + (role_o[3:2] == 2'd0) +
         (role_o[5:4] == 2'd0) + (role_o[7:6] == 2'd0)) == 1);

    assert_vec_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_SWEEP && vec_o != VEC_LAST) |=> vec_o == IN_W'($past(vec_o) + 1'b1));

    assert_ora_bit_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_SWEEP) |=> ora_bit_o == $past(resp0_i ^ resp1_i));

    assert_result_class_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> ($onehot0(loc_o) && $countones({|loc_o, nofault_o, outside_o}) == 1));

    assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    assert_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!start_i && state_q != ST_DECODE) |=> $stable({loc_o, nofault_o, outside_o}));

    assert_busy_start_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && state_q == ST_SWEEP) |=> state_q != ST_IDLE);

    assert_reset_R10: assert property (@(posedge clk_i)
        rst_i |=> (vec_o == '0 && !done_o && loc_o == '0 && !nofault_o && !outside_o));

endmodule

bind tile_diag_top tile_diag_chk #(.IN_W(IN_W)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .start_i   (start_i),
    .resp0_i   (resp0_i),
    .resp1_i   (resp1_i),
    .role_o    (role_o),
    .vec_o     (vec_o),
    .ora_bit_o (ora_bit_o),
    .done_o    (done_o),
    .loc_o     (loc_o),
    .nofault_o (nofault_o),
    .outside_o (outside_o),
    .state_q   (state_q)
);

// File: tb/sim_tile_diag_top.sv
module sim_tile_diag_top;

    localparam int IN_W   = 3;
    localparam int NV     = 1 << IN_W;
    localparam int SLOT   = NV + 1;
    localparam int DONE_AT = 4 * SLOT + 1;

    logic clk = 1'b0;
    logic rst, start, resp0, resp1;
    logic [7:0] role;
    logic [IN_W-1:0] vec;
    logic ora_bit, done, nofault, outside;
    logic [3:0] loc;

    int n_tests = 0;
    int n_fail = 0;

    logic use_force;
    logic [3:0] force_pat;
    logic [IN_W-1:0] force_vec;
    int fault_cell;
    logic [IN_W-1:0] fault_vec;
    int cur_sess;

    always #2 clk = ~clk;

    tile_diag_top #(.IN_W(IN_W)) u0 (
        .clk_i(clk), .rst_i(rst), .start_i(start),
        .resp0_i(resp0), .resp1_i(resp1),
        .role_o(role), .vec_o(vec), .ora_bit_o(ora_bit),
        .done_o(done), .loc_o(loc), .nofault_o(nofault), .outside_o(outside)
    );

    function automatic logic cell_out(int c, logic [IN_W-1:0] v);
        return (^v) ^ ((fault_cell == c) && (v == fault_vec));
    endfunction

    // Behavioural cells: session = index of the generator cell.
    always_comb begin
        int u0c, u1c;
        cur_sess = 0;
        u0c = 0;
        u1c = 0;
        for (int i = 0; i < 4; i++) begin
            if (role[2*i +: 2] == 2'd0) cur_sess = i;
            if (role[2*i +: 2] == 2'd2) u0c = i;
            if (role[2*i +: 2] == 2'd3) u1c = i;
        end
        if (use_force) begin
            resp0 = 1'b0;
            resp1 = force_pat[cur_sess] && (vec == force_vec);
        end else begin
            resp0 = cell_out(u0c, vec);
            resp1 = cell_out(u1c, vec);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_role(int s);
        logic [7:0] r;
        for (int i = 0; i < 4; i++) r[2*i +: 2] = 2'((s - i) & 3);
        return r;
    endfunction

    // Expected {loc, nofault, outside} from the signature table (bit s = session s+1 failed)
    function automatic logic [5:0] exp_decode(logic [3:0] p);
        case (p)
            4'b0000: return {4'b0000, 2'b10};
            4'b1100, 4'b1110: return {4'b0001, 2'b00};
            4'b1001, 4'b1101: return {4'b0010, 2'b00};
            4'b0011, 4'b1011: return {4'b0100, 2'b00};
            4'b0110, 4'b0111: return {4'b1000, 2'b00};
            default: return {4'b0000, 2'b01};
        endcase
    endfunction

    task automatic run_one(input logic [5:0] exp, input bit trace, input bit busy);
        bit early;
        early = 1'b0;
        @(negedge clk) start = 1'b1;
        for (int cyc = 0; cyc <= DONE_AT + 8; cyc++) begin
            @(negedge clk);
            if (cyc == 0) start = 1'b0;
            if (busy && cyc == 10) start = 1'b1;
            if (busy && cyc == 11) start = 1'b0;
            if (cyc < DONE_AT && done) early = 1'b1;
            if (trace) begin
                for (int s = 0; s < 4; s++) begin
                    for (int j = 0; j < NV; j++) begin
                        if (cyc == SLOT*s + j) begin
                            chk(vec == IN_W'(j), "R2 vector order", vec, j);
                            chk(role == exp_role(s), "R1 role map", role, exp_role(s));
                        end
                        if (cyc == SLOT*s + j + 1)
                            chk(ora_bit == (force_pat[s] && j == force_vec), "R3 ora bit",
                                ora_bit, (force_pat[s] && j == force_vec));
                    end
                end
            end
            if (cyc == DONE_AT) begin
                chk(!early, "R8 no early done", early, 0);
                chk(done == 1'b1, busy ? "R9 done after busy start" : "R8 done timing", done, 1);
                chk({loc, nofault, outside} == exp,
                    exp[5:2] != 0 ? "R5 cell location" : (exp[1] ? "R6 no fault" : "R7 outside"),
                    {loc, nofault, outside}, exp);
            end
            if (cyc == DONE_AT + 8) begin
                chk(done == 1'b0, "R8 done pulse", done, 0);
                chk({loc, nofault, outside} == exp, "R8 result held", {loc, nofault, outside}, exp);
            end
        end
    endtask

    initial begin
        #(200000 * 4);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        start = 1'b0;
        use_force = 1'b1;
        force_pat = 4'b0;
        force_vec = '0;
        fault_cell = -1;
        fault_vec = '0;
        repeat (5) @(negedge clk);
        chk(done == 0 && loc == 0 && !nofault && !outside, "R10 reset outputs",
            {done, loc, nofault, outside}, 0);
        chk(vec == 0, "R10 reset vector", vec, 0);
        chk(role == 8'b01_10_11_00, "R10 reset role map", role, 8'b01_10_11_00);
        rst = 1'b0;

        // Forced signatures: all 16 patterns (R4 through R7)
        for (int p = 0; p < 16; p++) begin
            force_pat = 4'(p);
            force_vec = IN_W'(p % NV);
            run_one(exp_decode(4'(p)), 1'b1, p == 5);
        end

        // Cell model: single faulty cell at every vector position (R4, R5)
        use_force = 1'b0;
        force_pat = 4'b0;
        for (int c = 0; c < 4; c++) begin
            for (int fv = 0; fv < NV; fv++) begin
                fault_cell = c;
                fault_vec = IN_W'(fv);
                run_one({4'(1 << c), 2'b00}, 1'b0, 1'b0);
            end
        end
        fault_cell = -1;
        run_one({4'b0000, 2'b10}, 1'b0, 1'b0);

        // Mid-run reset (R10)
        fault_cell = 1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (15) @(negedge clk);
        rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        chk(vec == 0 && role == 8'b01_10_11_00, "R10 mid-run reset counters", vec, 0);
        chk(loc == 0 && !done, "R10 mid-run reset outputs", loc, 0);
        begin
            bit seen;
            seen = 1'b0;
            repeat (DONE_AT + 10) begin
                @(negedge clk);
                if (done) seen = 1'b1;
            end
            chk(!seen, "R10 no done after reset", seen, 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule